// File: doc/BRIEF.md
# Privileged Scratch Register Bank

A bank of nine 32-bit scratch registers that software uses as fast temporary storage, plus one read-only identification register that holds a fixed version word. The registers have no hardware side effects. A move-to or move-from special-register operation reaches them. Each operation carries a 10-bit register number, a supervisor flag and write data.

The block decodes the register number and applies each group's privilege rule. For a read, it returns the data in the same cycle. For a write, it updates the addressed register at the next clock edge. When an access breaks a rule, the block raises a privilege-violation or illegal-access flag, leaves the stored state alone and drives the read data to zero.

The user scratch register is open to both modes. Supervisor scratch 0..3 are supervisor-only in both directions. Supervisor scratch 4..7 are readable from user mode, but only supervisor code may write them. Because of this, scratch 4..7 are read at one register number and written at another.

Top module: `spr_scratch_bank`

## Requirements
- R1: The user scratch register, at number 256, can be read and written in both modes, and a written value reads back on the next request.
- R2: Supervisor scratch i (0..3), at number 272+i, is read and written only when the supervisor flag is 1. The same access with the flag at 0 raises the privilege violation.
- R3: Supervisor scratch i (4..7) is written at number 272+i when the supervisor flag is 1. The same write with the flag at 0 raises the privilege violation.
- R4: Supervisor scratch i (4..7) reads in either mode at number 256+i (260..263) and returns its stored value.
- R5: A read of a write-only number (276..279) raises the illegal-access flag in supervisor mode and the privilege violation in user mode.
- R6: A supervisor read of number 287 returns the parameter VER_VALUE. A user read of number 287 raises the privilege violation.
- R7: A write to a read-only number (287 or 260..263) changes no register. It raises the illegal-access flag in supervisor mode and the privilege violation in user mode.
- R8: An access to any other register number raises the illegal-access flag in either mode and changes no register.
- R9: On any violation or illegal access, no register changes, the read data is zero, and at most one of the two flags is high.
- R10: An active-low asynchronous reset clears all nine scratch registers to zero.
- R11: With no valid request, or on any write, the read data is zero. With no valid request, both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | An access is presented this cycle |
| req_write_i | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_priv_i | input | 1 | 1 = supervisor mode, 0 = user mode |
| req_num_i | input | 10 | Special register number |
| req_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data; zero unless a read succeeds |
| priv_viol_o | output | 1 | Access lacks the needed privilege (high for the request's cycle) |
| illegal_o | output | 1 | Unknown number or wrong direction |

## Verification
The assertions assume that the request inputs are known and stable for the whole cycle in which req_valid_i is high. They also assume that each request lasts exactly one cycle, so each flag shows as a one-cycle pulse per request. The bench changes the inputs only at the falling edge and samples the outputs shortly afterwards. This keeps every request within one clock period. Register numbers are drawn mostly from the decoded set, with some drawn from the full 10-bit range, so that both the rules and the unknown-number path see traffic.

// File: rtl/spr_bank_pkg.sv
package spr_bank_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned NUM_W   = 10;
  localparam int unsigned SUP_CNT = 8;
  localparam int unsigned SPLIT   = 4;  // first user-readable supervisor index

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_USER,
    CLS_SUP_RW,
    CLS_SUP_WO,
    CLS_ALIAS_RO,
    CLS_VER
  } spr_cls_e;
endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_bank_pkg::*;
#(
  parameter int unsigned NUM_W      = spr_bank_pkg::NUM_W,
  parameter int unsigned SUP_CNT    = spr_bank_pkg::SUP_CNT,
  parameter int unsigned SPLIT      = spr_bank_pkg::SPLIT,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned USER_NUM   = 256,
  parameter int unsigned SUP_BASE   = 272,
  parameter int unsigned ALIAS_BASE = 260,
  parameter int unsigned VER_NUM    = 287
) (
  input  logic [NUM_W-1:0] num_i,
  output spr_cls_e         cls_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [NUM_W-1:0] USER_N = NUM_W'(USER_NUM);
  localparam logic [NUM_W-1:0] VER_N  = NUM_W'(VER_NUM);

  always_comb begin
    cls_o = CLS_NONE;
    idx_o = '0;
    if (num_i == USER_N) begin
      cls_o = CLS_USER;
      idx_o = IDX_W'(SUP_CNT);
    end else if (num_i == VER_N) begin
      cls_o = CLS_VER;
    end else begin
      for (int i = 0; i < int'(SUP_CNT); i++) begin
        if (num_i == NUM_W'(SUP_BASE + i)) begin
          cls_o = (i < int'(SPLIT)) ? CLS_SUP_RW : CLS_SUP_WO;
          idx_o = IDX_W'(i);
        end
        if (i >= int'(SPLIT) && num_i == NUM_W'(ALIAS_BASE + i - SPLIT)) begin
          cls_o = CLS_ALIAS_RO;
          idx_o = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/spr_access_check.sv
module spr_access_check
  import spr_bank_pkg::*;
(
  input  logic     valid_i,
  input  logic     write_i,
  input  logic     priv_i,
  input  spr_cls_e cls_i,
  output logic     wr_ok_o,
  output logic     rd_ok_o,
  output logic     viol_o,
  output logic     illegal_o
);
  logic need_priv;
  logic allowed;

  always_comb begin
    unique case (cls_i)
      CLS_USER:     begin need_priv = 1'b0;    allowed = 1'b1;     end
      CLS_SUP_RW:   begin need_priv = 1'b1;    allowed = 1'b1;     end
      CLS_SUP_WO:   begin need_priv = 1'b1;    allowed = write_i;  end
      CLS_ALIAS_RO: begin need_priv = write_i; allowed = !write_i; end
      CLS_VER:      begin need_priv = 1'b1;    allowed = !write_i; end
      default:      begin need_priv = 1'b0;    allowed = 1'b0;     end
    endcase
  end

  // privilege is judged before direction
  assign viol_o    = valid_i && need_priv && !priv_i;
  assign illegal_o = valid_i && !viol_o && !allowed;
  assign wr_ok_o   = valid_i && !viol_o && allowed && write_i;
  assign rd_ok_o   = valid_i && !viol_o && allowed && !write_i;
endmodule

// File: rtl/spr_reg_file.sv
module spr_reg_file #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREG   = 9,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [NREG-1:0][DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < int'(NREG); g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_o[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))     regs_o[g] <= wr_data_i;
    end
  end

  // R10
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |-> regs_o == '0);
endmodule

// File: rtl/spr_scratch_bank.sv
module spr_scratch_bank
  import spr_bank_pkg::*;
#(
  parameter int unsigned      DATA_W     = spr_bank_pkg::DATA_W,
  parameter int unsigned      NUM_W      = spr_bank_pkg::NUM_W,
  parameter int unsigned      SUP_CNT    = spr_bank_pkg::SUP_CNT,
  parameter int unsigned      SPLIT      = spr_bank_pkg::SPLIT,
  parameter int unsigned      USER_NUM   = 256,
  parameter int unsigned      SUP_BASE   = 272,
  parameter int unsigned      ALIAS_BASE = 260,
  parameter int unsigned      VER_NUM    = 287,
  parameter logic [DATA_W-1:0] VER_VALUE = 32'h7A31_0205
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_priv_i,
  input  logic [NUM_W-1:0]  req_num_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              priv_viol_o,
  output logic              illegal_o
);
  localparam int unsigned NREG     = SUP_CNT + 1;
  localparam int unsigned IDX_W    = $clog2(NREG);
  localparam int unsigned USER_IDX = SUP_CNT;

  spr_cls_e                    cls;
  logic [IDX_W-1:0]            idx;
  logic                        wr_ok, rd_ok;
  logic [NREG-1:0][DATA_W-1:0] regs;

  spr_decode #(
    .NUM_W(NUM_W), .SUP_CNT(SUP_CNT), .SPLIT(SPLIT), .IDX_W(IDX_W),
    .USER_NUM(USER_NUM), .SUP_BASE(SUP_BASE), .ALIAS_BASE(ALIAS_BASE), .VER_NUM(VER_NUM)
  ) u_decode (
    .num_i (req_num_i),
    .cls_o (cls),
    .idx_o (idx)
  );

  spr_access_check u_check (
    .valid_i   (req_valid_i),
    .write_i   (req_write_i),
    .priv_i    (req_priv_i),
    .cls_i     (cls),
    .wr_ok_o   (wr_ok),
    .rd_ok_o   (rd_ok),
    .viol_o    (priv_viol_o),
    .illegal_o (illegal_o)
  );

  spr_reg_file #(.DATA_W(DATA_W), .NREG(NREG), .IDX_W(IDX_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_ok),
    .wr_idx_i  (idx),
    .wr_data_i (req_wdata_i),
    .regs_o    (regs)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_ok) rd_data_o = (cls == CLS_VER) ? VER_VALUE : regs[idx];
  end

  // R9
  no_write_on_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (priv_viol_o || illegal_o) |=> $stable(regs));
  // R9
  fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({priv_viol_o, illegal_o}));
  // R9
  fault_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_viol_o || illegal_o) |-> rd_data_o == '0);
  // R6
  ver_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i && req_priv_i && req_num_i == NUM_W'(VER_NUM)
    |-> rd_data_o == VER_VALUE);
  // R1
  user_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_write_i && req_num_i == NUM_W'(USER_NUM)
    |=> regs[USER_IDX] == $past(req_wdata_i));
  // R3
  user_sup_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_write_i && !req_priv_i &&
    req_num_i >= NUM_W'(SUP_BASE) && req_num_i < NUM_W'(SUP_BASE + SUP_CNT)
    |-> priv_viol_o);
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !priv_viol_o && !illegal_o && rd_data_o == '0);
endmodule

// File: tb/spr_scratch_bank_bench.sv
`timescale 1ns/1ps
module spr_scratch_bank_bench;
  localparam logic [31:0] VER = 32'h7A31_0205;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        v = 1'b0, w = 1'b0, p = 1'b0;
  logic [9:0]  num = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        viol, ill;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [9];

  always #2.5 clk = ~clk;

  spr_scratch_bank u_spr_scratch_bank (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(v), .req_write_i(w), .req_priv_i(p),
    .req_num_i(num), .req_wdata_i(wd), .rd_data_o(rd), .priv_viol_o(viol), .illegal_o(ill)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s num=%0d actual=%h expected=%h", tag, what, num, act, exp);
    end
  endtask

  function automatic void ref_eval(input bit vv, ww, pp, input int n,
                                   output logic [31:0] erd, output bit ev, ei, output int widx);
    int  idx = 0;
    bit  need = 0, allow = 0, ver = 0;
    erd = '0; ev = 0; ei = 0; widx = -1;
    if (!vv) return;
    if (n == 256)                 begin idx = 8;       allow = 1;                end
    else if (n == 287)            begin ver = 1;       need = 1; allow = !ww;    end
    else if (n >= 272 && n <= 275) begin idx = n - 272; need = 1; allow = 1;     end
    else if (n >= 276 && n <= 279) begin idx = n - 272; need = 1; allow = ww;    end
    else if (n >= 260 && n <= 263) begin idx = n - 256; need = ww; allow = !ww;  end
    if (need && !pp)  ev = 1;
    else if (!allow)  ei = 1;
    else if (ww)      widx = idx;
    else              erd = ver ? VER : model[idx];
  endfunction

  task automatic step(bit sv, bit sw, bit sp, int sn, logic [31:0] swd, string tag);
    logic [31:0] erd;
    bit ev, ei;
    int widx;
    @(negedge clk);
    v = sv; w = sw; p = sp; num = 10'(sn); wd = swd;
    #1;
    ref_eval(sv, sw, sp, sn, erd, ev, ei, widx);
    chk(tag, "rd_data", rd, erd);
    chk(tag, "priv_viol", 32'(viol), 32'(ev));
    chk(tag, "illegal", 32'(ill), 32'(ei));
    if (widx >= 0) model[widx] = swd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; v = 1'b0;
    foreach (model[i]) model[i] = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic read_all(string tag);
    step(1, 0, 1, 256, 0, tag);
    for (int i = 0; i < 4; i++) step(1, 0, 1, 272 + i, 0, tag);
    for (int i = 4; i < 8; i++) step(1, 0, 0, 256 + i, 0, tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    foreach (model[i]) model[i] = '0;
    do_reset();
    read_all("R10");
    // R1 user register both modes
    step(1, 1, 0, 256, 32'hA5A5_0001, "R1");
    step(1, 0, 0, 256, 0, "R1");
    step(1, 1, 1, 256, 32'h0BAD_F00D, "R1");
    step(1, 0, 0, 256, 0, "R1");
    // R2 supervisor-only group
    for (int i = 0; i < 4; i++) step(1, 1, 1, 272 + i, 32'h1000_0000 + i, "R2");
    for (int i = 0; i < 4; i++) step(1, 0, 1, 272 + i, 0, "R2");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 272 + i, 32'hDEAD_0000, "R2");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 272 + i, 0, "R2");
    // R3 split group writes
    for (int i = 4; i < 8; i++) step(1, 1, 1, 272 + i, 32'h2000_0000 + i, "R3");
    for (int i = 4; i < 8; i++) step(1, 1, 0, 272 + i, 32'hBEEF_0000, "R3");
    // R4 user-readable aliases
    for (int i = 4; i < 8; i++) step(1, 0, 0, 256 + i, 0, "R4");
    for (int i = 4; i < 8; i++) step(1, 0, 1, 256 + i, 0, "R4");
    // R5 reads of write-only numbers
    for (int i = 4; i < 8; i++) step(1, 0, 1, 272 + i, 0, "R5");
    for (int i = 4; i < 8; i++) step(1, 0, 0, 272 + i, 0, "R5");
    // R6 version
    step(1, 0, 1, 287, 0, "R6");
    step(1, 0, 0, 287, 0, "R6");
    // R7 writes to read-only numbers
    step(1, 1, 1, 287, 32'h1111_1111, "R7");
    step(1, 1, 0, 287, 32'h2222_2222, "R7");
    step(1, 1, 1, 260, 32'h3333_3333, "R7");
    step(1, 1, 0, 263, 32'h4444_4444, "R7");
    read_all("R7");
    // R8 unknown numbers
    step(1, 1, 1, 0, 32'h5555_5555, "R8");
    step(1, 0, 0, 1023, 0, "R8");
    step(1, 1, 1, 264, 32'h6666_6666, "R8");
    step(1, 0, 1, 280, 0, "R8");
    step(1, 1, 0, 255, 32'h7777_7777, "R8");
    read_all("R8");
    // R11 idle and write cycles
    step(0, 0, 1, 256, 0, "R11");
    step(0, 1, 0, 287, 32'hFFFF_FFFF, "R11");
    step(1, 1, 1, 256, 32'hCAFE_0000, "R11");
    // R9 mixed traffic
    for (int k = 0; k < 3000; k++) begin
      int sel = $urandom_range(0, 9);
      int n;
      if (sel == 0)      n = $urandom_range(0, 1023);
      else if (sel < 3)  n = 256 + $urandom_range(0, 7);
      else if (sel < 8)  n = 272 + $urandom_range(0, 7);
      else if (sel == 8) n = 287;
      else               n = 256;
      step($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, n, $urandom, "R9");
    end
    read_all("R9");
    // R10 reset mid-run clears everything
    do_reset();
    read_all("R10");
    finish_run();
  end
endmodule